// File: doc/BRIEF.md
# SD SPI Block Write Engine

This block carries the data phase of a card write over SPI, after the write command has already been accepted by the card. It moves one or more payload blocks from a ready/valid byte stream to an SPI master through a byte-exchange port. It frames every block with a fill byte, a start token and a trailing CRC16. It then looks for the card's data-response token, decodes it, and waits while the card signals busy.

A transfer is launched with a one-cycle `start` pulse that carries the block count, the block size and a single/multi flag. In multi mode, once every block has been accepted, the engine sends the stop-transfer token and waits out busy a second time. The transfer ends with a one-cycle `done` pulse and an 8-bit `status`: 0x00 for success, 0x08 for a rejected block and 0x80 for a busy timeout. Command issue and chip-select control belong to the surrounding logic.

One byte is exchanged in each cycle in which `spi_req` and `spi_ack` are both high. In that same cycle the master presents the received byte on `spi_rx`.

Top module: `sdw_write_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `spi_req` and `in_ready` are low and `status` is 0x00.
- R2: Each block is sent as 0xFF, then the start token, then exactly `blk_size` payload bytes in stream order, then the CRC16 of the payload (polynomial 0x1021, initial value 0), high byte first. The start token is 0xFE in single mode and 0xFC in multi mode. A block size of 0 sends no payload and a CRC of 0x0000. Every exchange made only to read sends 0xFF.
- R3: `in_ready` is high only in a cycle where a payload byte is exchanged (`in_valid` and `spi_ack` both high during the payload phase). While `in_valid` is low in that phase, no exchange is requested.
- R4: After the CRC the engine reads at most RESP_TRIES (8) bytes and stops at the first byte whose bit 4 is 0.
- R5: The response is judged on its low 5 bits. 0x05 means accepted. Any other value, including 0x0B, 0x0D or no token within the read limit, ends the transfer with status 0x08 and no further exchange.
- R6: After an accepted block the engine reads until it receives 0xFF. The first read of the wait never counts as ready. It then starts the next block or finishes.
- R7: If BUSY_LIMIT reads of a busy wait pass without completing it, the transfer ends with status 0x80.
- R8: In multi mode, after the last block is accepted, the engine sends 0xFF and then 0xFD, and then runs the same busy wait. Completion gives status 0x00 and a timeout gives 0x80.
- R9: In multi mode, a transfer ended by a rejected block sends no stop sequence.
- R10: A block count of 0 sends only the stop sequence in multi mode. In single mode it finishes with status 0x00 and no exchange.
- R11: `busy` is high from the cycle after an accepted `start` until the cycle `done` pulses. `done` lasts one cycle, and `status` holds its value until the next completion.
- R12: A `start` pulse that arrives while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only while idle |
| multi | input | 1 | 1 selects multi-block framing with a stop token |
| blk_count | input | CNT_W | Number of blocks, sampled with `start` |
| blk_size | input | SIZE_W | Payload bytes per block, sampled with `start` |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte taken this cycle |
| spi_req | output | 1 | Byte exchange requested |
| spi_tx | output | 8 | Byte to transmit |
| spi_ack | input | 1 | Exchange happens this cycle |
| spi_rx | input | 8 | Byte received in the exchange |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Final status: 0x00, 0x08 or 0x80 |

## Verification
An exchange happens at the rising edge where `spi_req` and `spi_ack` are both high, and the next request reflects it one cycle later. `in_ready` is combinational, so it is due in the same cycle as the payload exchange. `done` and `status` are registered and appear in the cycle after the exchange that decided the outcome. With a count of 0 in single mode, they appear in the cycle after `start`. The bench drives `spi_ack`, `spi_rx` and the payload stream after the falling edge, lets the combinational outputs settle, and checks `spi_tx` and `in_ready` before the next rising edge. It checks `busy`, `done` and `status` 1 ns after a rising edge. Every exchange is compared against a queue of expected bytes built from the requirements, so an extra, missing or reordered byte is caught at the exchange where it occurs.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TOKEN,
        ST_DATA,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_RESP,
        ST_BUSY,
        ST_STOP_LEAD,
        ST_STOP_TOK,
        ST_STOP_BUSY
    } sdw_state_e;

    typedef struct packed {
        logic       fire;
        logic [7:0] code;
    } sdw_result_t;

    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam logic [7:0] TOK_SINGLE = 8'hFE;
    localparam logic [7:0] TOK_MULTI  = 8'hFC;
    localparam logic [7:0] TOK_STOP   = 8'hFD;
    localparam logic [4:0] RESP_OK    = 5'h05;

    localparam logic [7:0] STAT_OK      = 8'h00;
    localparam logic [7:0] STAT_REJECT  = 8'h08;
    localparam logic [7:0] STAT_TIMEOUT = 8'h80;

    // Folds one byte into a CRC16 (x^16 + x^12 + x^5 + 1), MSB of the byte first.
    function automatic logic [15:0] crc16_next(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/sdw_crc16.sv
module sdw_crc16 (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        step,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    import sdw_pkg::*;

    logic [15:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) acc_q <= 16'h0000;
        else if (step)    acc_q <= crc16_next(acc_q, data);
    end

    assign crc = acc_q;
endmodule

// File: rtl/sdw_poll_ctr.sv
module sdw_poll_ctr #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    output logic first,
    output logic last
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST_VAL = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else if (inc)     cnt_q <= cnt_q + W'(1);
    end

    assign first = (cnt_q == '0);
    assign last  = (cnt_q == LAST_VAL);
endmodule

// File: rtl/sdw_block_track.sv
module sdw_block_track #(
    parameter int CNT_W  = 16,
    parameter int SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [SIZE_W-1:0] size_in,
    input  logic              byte_step,
    input  logic              block_step,
    output logic              size_zero,
    output logic              byte_last,
    output logic              block_last
);
    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] byte_idx_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  blk_idx_q;

    assign size_zero  = (size_q == '0);
    assign byte_last  = (byte_idx_q == size_q - SIZE_W'(1));
    assign block_last = (blk_idx_q == count_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q     <= '0;
            count_q    <= '0;
            byte_idx_q <= '0;
            blk_idx_q  <= '0;
        end else if (load) begin
            size_q     <= size_in;
            count_q    <= count_in;
            byte_idx_q <= '0;
            blk_idx_q  <= '0;
        end else begin
            if (byte_step)  byte_idx_q <= byte_last ? '0 : byte_idx_q + SIZE_W'(1);
            if (block_step) blk_idx_q  <= blk_idx_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sdw_write_engine.sv
module sdw_write_engine #(
    parameter int CNT_W      = 16,
    parameter int SIZE_W     = 12,
    parameter int RESP_TRIES = 8,
    parameter int BUSY_LIMIT = 3000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              multi,
    input  logic [CNT_W-1:0]  blk_count,
    input  logic [SIZE_W-1:0] blk_size,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              spi_req,
    output logic [7:0]        spi_tx,
    input  logic              spi_ack,
    input  logic [7:0]        spi_rx,
    output logic              busy,
    output logic              done,
    output logic [7:0]        status
);
    import sdw_pkg::*;

    sdw_state_e  state_q, state_d;
    logic        multi_q;
    logic        done_q;
    logic [7:0]  status_q;
    sdw_result_t result;

    logic        xfer;
    logic        load;
    logic        crc_clear, crc_step;
    logic [15:0] crc;
    logic        byte_step, block_step;
    logic        size_zero, byte_last, block_last;
    logic        resp_clr, resp_inc, resp_first, resp_last;
    logic        poll_clr, poll_inc, poll_first, poll_last;
    logic        rx_ready;

    assign xfer     = spi_req && spi_ack;
    assign rx_ready = (spi_rx == FILL_BYTE);

    sdw_crc16 u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (crc_clear),
        .step  (crc_step),
        .data  (in_data),
        .crc   (crc)
    );

    sdw_block_track #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .count_in   (blk_count),
        .size_in    (blk_size),
        .byte_step  (byte_step),
        .block_step (block_step),
        .size_zero  (size_zero),
        .byte_last  (byte_last),
        .block_last (block_last)
    );

    sdw_poll_ctr #(.LIMIT(RESP_TRIES)) u_resp_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (resp_clr),
        .inc   (resp_inc),
        .first (resp_first),
        .last  (resp_last)
    );

    sdw_poll_ctr #(.LIMIT(BUSY_LIMIT)) u_busy_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (poll_clr),
        .inc   (poll_inc),
        .first (poll_first),
        .last  (poll_last)
    );

    always_comb begin
        state_d    = state_q;
        result     = '{fire: 1'b0, code: STAT_OK};
        load       = 1'b0;
        crc_clear  = 1'b0;
        crc_step   = 1'b0;
        byte_step  = 1'b0;
        block_step = 1'b0;
        resp_clr   = 1'b0;
        resp_inc   = 1'b0;
        poll_clr   = 1'b0;
        poll_inc   = 1'b0;
        spi_req    = 1'b0;
        spi_tx     = FILL_BYTE;

        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (blk_count != '0)  state_d = ST_LEAD;
                    else if (multi)       state_d = ST_STOP_LEAD;
                    else                  result  = '{fire: 1'b1, code: STAT_OK};
                end
            end

            ST_LEAD: begin
                spi_req = 1'b1;
                if (xfer) begin
                    crc_clear = 1'b1;
                    state_d   = ST_TOKEN;
                end
            end

            ST_TOKEN: begin
                spi_req = 1'b1;
                spi_tx  = multi_q ? TOK_MULTI : TOK_SINGLE;
                if (xfer) state_d = size_zero ? ST_CRC_HI : ST_DATA;
            end

            ST_DATA: begin
                spi_req = in_valid;
                spi_tx  = in_data;
                if (xfer) begin
                    crc_step  = 1'b1;
                    byte_step = 1'b1;
                    if (byte_last) state_d = ST_CRC_HI;
                end
            end

            ST_CRC_HI: begin
                spi_req = 1'b1;
                spi_tx  = crc[15:8];
                if (xfer) state_d = ST_CRC_LO;
            end

            ST_CRC_LO: begin
                spi_req = 1'b1;
                spi_tx  = crc[7:0];
                if (xfer) begin
                    resp_clr = 1'b1;
                    state_d  = ST_RESP;
                end
            end

            ST_RESP: begin
                spi_req = 1'b1;
                if (xfer) begin
                    resp_inc = 1'b1;
                    if (!spi_rx[4] || resp_last) begin
                        if (spi_rx[4:0] == RESP_OK) begin
                            poll_clr = 1'b1;
                            state_d  = ST_BUSY;
                        end else begin
                            result  = '{fire: 1'b1, code: STAT_REJECT};
                            state_d = ST_IDLE;
                        end
                    end
                end
            end

            ST_BUSY: begin
                spi_req = 1'b1;
                if (xfer) begin
                    poll_inc = 1'b1;
                    if (!poll_first && rx_ready) begin
                        block_step = 1'b1;
                        if (!block_last) begin
                            state_d = ST_LEAD;
                        end else if (multi_q) begin
                            state_d = ST_STOP_LEAD;
                        end else begin
                            result  = '{fire: 1'b1, code: STAT_OK};
                            state_d = ST_IDLE;
                        end
                    end else if (poll_last) begin
                        result  = '{fire: 1'b1, code: STAT_TIMEOUT};
                        state_d = ST_IDLE;
                    end
                end
            end

            ST_STOP_LEAD: begin
                spi_req = 1'b1;
                if (xfer) state_d = ST_STOP_TOK;
            end

            ST_STOP_TOK: begin
                spi_req = 1'b1;
                spi_tx  = TOK_STOP;
                if (xfer) begin
                    poll_clr = 1'b1;
                    state_d  = ST_STOP_BUSY;
                end
            end

            ST_STOP_BUSY: begin
                spi_req = 1'b1;
                if (xfer) begin
                    poll_inc = 1'b1;
                    if (!poll_first && rx_ready) begin
                        result  = '{fire: 1'b1, code: STAT_OK};
                        state_d = ST_IDLE;
                    end else if (poll_last) begin
                        result  = '{fire: 1'b1, code: STAT_TIMEOUT};
                        state_d = ST_IDLE;
                    end
                end
            end

            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            multi_q  <= 1'b0;
            done_q   <= 1'b0;
            status_q <= STAT_OK;
        end else begin
            state_q <= state_d;
            done_q  <= result.fire;
            if (load)        multi_q  <= multi;
            if (result.fire) status_q <= result.code;
        end
    end

    assign in_ready = (state_q == ST_DATA) && in_valid && spi_ack;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign status   = status_q;

    // resp_first is only meaningful for debug visibility of the try counter
    logic resp_first_unused;
    assign resp_first_unused = resp_first;
endmodule

// File: rtl/sdw_write_engine_chk.sv
module sdw_write_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic [7:0] status,
    input logic       spi_req,
    input logic       spi_ack,
    input logic       in_valid,
    input logic       in_ready
);
    // R1
    idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !spi_req);

    // R3
    ready_on_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (spi_req && spi_ack && in_valid));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R11
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(status));

    // R5
    status_code_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (status == 8'h00 || status == 8'h08 || status == 8'h80));
endmodule

bind sdw_write_engine sdw_write_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .status   (status),
    .spi_req  (spi_req),
    .spi_ack  (spi_ack),
    .in_valid (in_valid),
    .in_ready (in_ready)
);

// File: tb/sdw_write_engine_tb.sv
`timescale 1ns/1ps
module sdw_write_engine_tb;
    localparam int CNT_W  = 8;
    localparam int SIZE_W = 8;
    localparam int BLIM   = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              multi = 1'b0;
    logic [CNT_W-1:0]  blk_count = '0;
    logic [SIZE_W-1:0] blk_size = '0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = 8'h00;
    logic              in_ready;
    logic              spi_req;
    logic [7:0]        spi_tx;
    logic              spi_ack = 1'b0;
    logic [7:0]        spi_rx = 8'hFF;
    logic              busy;
    logic              done;
    logic [7:0]        status;

    sdw_write_engine #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .RESP_TRIES(8), .BUSY_LIMIT(BLIM)) u_dut (
        .clk(clk), .rst(rst), .start(start), .multi(multi),
        .blk_count(blk_count), .blk_size(blk_size),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx),
        .busy(busy), .done(done), .status(status)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_tag = "R1";
    bit    stall_in = 1'b0;
    bit    stall_ack = 1'b0;

    logic [7:0] exp_tx[$];
    logic [7:0] card_rx[$];
    bit         exp_pay[$];
    logic [7:0] pay_q[$];

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 7; b >= 0; b--) begin
            logic fb;
            fb = r[15] ^ d[b];
            r  = r << 1;
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic push(input logic [7:0] tx, input logic [7:0] rx, input bit pay);
        exp_tx.push_back(tx);
        card_rx.push_back(rx);
        exp_pay.push_back(pay);
    endtask

    task automatic push_read(input logic [7:0] rx);
        push(8'hFF, rx, 1'b0);
    endtask

    task automatic push_block(input bit m, input int size, input int seed);
        logic [15:0] c;
        c = 16'h0000;
        push(8'hFF, 8'hFF, 1'b0);
        push(m ? 8'hFC : 8'hFE, 8'hFF, 1'b0);
        for (int i = 0; i < size; i++) begin
            logic [7:0] v;
            v = 8'((seed * 31 + i * 17 + 3) & 255);
            pay_q.push_back(v);
            push(v, 8'hFF, 1'b1);
            c = crc_upd(c, v);
        end
        push(c[15:8], 8'hFF, 1'b0);
        push(c[7:0], 8'hFF, 1'b0);
    endtask

    task automatic push_stop();
        push(8'hFF, 8'hFF, 1'b0);
        push(8'hFD, 8'hFF, 1'b0);
    endtask

    // Card and payload source: drive after the falling edge, check before the rising edge.
    always @(negedge clk) begin
        in_valid = (pay_q.size() > 0) && !(stall_in && (cyc % 3 == 1));
        in_data  = (pay_q.size() > 0) ? pay_q[0] : 8'h00;
        #0.5;
        if (spi_req && !(stall_ack && (cyc % 2 == 1))) begin
            bit pay;
            spi_ack = 1'b1;
            if (exp_tx.size() == 0) begin
                check(cur_tag, "unexpected exchange", {8'h00, spi_tx}, 16'hDEAD);
                spi_rx = 8'hFF;
                pay    = 1'b0;
            end else begin
                check(cur_tag, "tx byte", {8'h00, spi_tx}, {8'h00, exp_tx.pop_front()});
                spi_rx = card_rx.pop_front();
                pay    = exp_pay.pop_front();
            end
            #0.5;
            // R3: in_ready exactly on payload exchanges
            check("R3", "in_ready on exchange", {15'h0, in_ready}, {15'h0, pay});
            if (pay && pay_q.size() > 0) void'(pay_q.pop_front());
        end else begin
            spi_ack = 1'b0;
            spi_rx  = 8'hFF;
            #0.5;
            check("R3", "in_ready idle", {15'h0, in_ready}, 16'h0);
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run(input bit m, input int cnt, input int size, input logic [7:0] exp_st,
                       input string tag, input int poke_at);
        bit got;
        cur_tag   = tag;
        multi     = m;
        blk_count = CNT_W'(cnt);
        blk_size  = SIZE_W'(size);
        start     = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        // R11: busy from the cycle after start
        check("R11", "busy after start", {15'h0, busy}, {15'h0, !(cnt == 0 && !m)});
        got = 1'b0;
        for (int k = 0; k < 3000 && !got; k++) begin
            if (done) begin
                got = 1'b1;
            end else begin
                if (k == poke_at) begin
                    start = 1'b1; multi = !m; blk_count = CNT_W'(3);
                end
                @(posedge clk); #1;
                start = 1'b0;
            end
        end
        check(tag, "done seen", {15'h0, got}, 16'h1);
        check(tag, "status", {8'h00, status}, {8'h00, exp_st});
        check(tag, "leftover exchanges", 16'(exp_tx.size()), 16'h0);
        check(tag, "leftover payload", 16'(pay_q.size()), 16'h0);
        @(posedge clk); #1;
        // R11: one-cycle pulse and held status
        check("R11", "done cleared", {15'h0, done}, 16'h0);
        check("R11", "status held", {8'h00, status}, {8'h00, exp_st});
        exp_tx.delete(); card_rx.delete(); exp_pay.delete(); pay_q.delete();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        check("R1", "busy", {15'h0, busy}, 16'h0);
        check("R1", "done", {15'h0, done}, 16'h0);
        check("R1", "spi_req", {15'h0, spi_req}, 16'h0);
        check("R1", "in_ready", {15'h0, in_ready}, 16'h0);
        check("R1", "status", {8'h00, status}, 16'h0);

        // R2 R4 R6: single block, token after one fill byte, first busy poll 0xFF ignored
        push_block(1'b0, 4, 1);
        push_read(8'hFF); push_read(8'hE5);
        push_read(8'hFF); push_read(8'h00); push_read(8'hFF);
        run(1'b0, 4 / 4, 4, 8'h00, "R6", -1);

        // R8 R3: two multi blocks with stalls on both sides, then stop sequence
        stall_in = 1'b1; stall_ack = 1'b1;
        push_block(1'b1, 3, 2); push_read(8'h05); push_read(8'h00); push_read(8'hFF);
        push_block(1'b1, 3, 3); push_read(8'hFF); push_read(8'h05); push_read(8'h00); push_read(8'h00); push_read(8'hFF);
        push_stop(); push_read(8'h00); push_read(8'hFF);
        run(1'b1, 2, 3, 8'h00, "R8", -1);
        stall_in = 1'b0; stall_ack = 1'b0;

        // R5: CRC rejection code
        push_block(1'b0, 2, 4); push_read(8'h0B);
        run(1'b0, 1, 2, 8'h08, "R5", -1);

        // R9: write error on second multi block, no stop sequence
        push_block(1'b1, 2, 5); push_read(8'h05); push_read(8'h00); push_read(8'hFF);
        push_block(1'b1, 2, 6); push_read(8'h0D);
        run(1'b1, 3, 2, 8'h08, "R9", -1);

        // R4: eight reads without a token
        push_block(1'b0, 1, 7);
        for (int i = 0; i < 8; i++) push_read(8'hFF);
        run(1'b0, 1, 1, 8'h08, "R4", -1);

        // R7: busy wait runs out after BLIM reads
        push_block(1'b0, 1, 8); push_read(8'h05);
        for (int i = 0; i < BLIM; i++) push_read(8'h00);
        run(1'b0, 1, 1, 8'h80, "R7", -1);

        // R8: stop busy timeout
        push_block(1'b1, 1, 9); push_read(8'h05); push_read(8'h00); push_read(8'hFF);
        push_stop();
        for (int i = 0; i < BLIM; i++) push_read(8'h00);
        run(1'b1, 1, 1, 8'h80, "R8", -1);

        // R10: zero blocks, multi then single
        push_stop(); push_read(8'h00); push_read(8'hFF);
        run(1'b1, 0, 4, 8'h00, "R10", -1);
        run(1'b0, 0, 4, 8'h00, "R10", -1);

        // R2: zero-size block carries a zero CRC
        push_block(1'b0, 0, 10); push_read(8'h05); push_read(8'h00); push_read(8'hFF);
        run(1'b0, 1, 0, 8'h00, "R2", -1);

        // R12: start pulse during a transfer is ignored
        stall_in = 1'b1;
        push_block(1'b0, 6, 11); push_read(8'h05); push_read(8'h00); push_read(8'hFF);
        run(1'b0, 1, 6, 8'h00, "R12", 5);
        stall_in = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule